// File: doc/BRIEF.md
# SPI Command Transaction Sequencer

This block runs one framed SPI master transaction for each 32-bit command word it accepts. The command picks one of four active-low chip selects, gives the frame length in bytes, and gives a count of leading bytes that are only transmitted. It also carries two flags. One makes the frame transmit-only. The other reads the bytes that follow the leading count over two data lines at once. Transmit bytes come from a ready/valid stream fed by a FIFO. Received bytes leave as single-cycle pushes toward a receive FIFO, and a one-cycle done pulse closes the frame.

The serial clock runs in mode 0: it idles low, the slave samples on the rising edge and data changes after the falling edge. The clock advances only on a one-cycle step strobe, which comes from a separate per-select rate block that owns the divider and the chip-select setup and hold timing. The bit order is most-significant first. The reset input is asynchronous and active low, and it must be released synchronously to the clock by the reset tree.

Top module: `spi_cmd_seq`

## Requirements
- R1: Command bits 31:30 choose which `spi_cs_n` line is driven low. Exactly that line stays low from the cycle after the command is accepted until the frame ends, and all lines are high when idle.
- R2: Command bits 15:0 hold the frame length minus one, so a frame carries 1 to 65536 bytes. A single-line byte takes 8 rising serial clock edges.
- R3: Command bits 23:16 hold a skip count. Each of the first skip-count bytes is taken from the transmit stream and shifted out, and none of them is pushed to the receive side.
- R4: When the skip count is nonzero, every byte after it drives zeros on `spi_sdo`, takes nothing from the transmit stream, and is pushed to the receive side. When the skip count is zero, every byte is both taken from the transmit stream and pushed.
- R5: Command bit 27 set (transmit-only) means no byte of the frame is pushed to the receive side.
- R6: Command bit 28 set with a nonzero skip count makes every byte after the skip take 4 rising edges. Each edge captures `spi_sdi[1]` as the higher bit and `spi_sdi[0]` as the lower bit, and `spi_sdo_oe` is low for those bytes. With a zero skip count, bit 28 has no effect.
- R7: `done` is high for exactly one cycle, in the first cycle in which all chip selects are high again after the last byte.
- R8: While a byte that needs transmit data is due and `tx_valid` is low, `tx_ready` stays high, the serial clock holds its level and the chip select stays low.
- R9: A command offered while a frame is in progress is ignored. The frame continues on its original select and with its original length.
- R10: `spi_sck` changes only in the cycle after `sck_step` was high. Each received byte is assembled most-significant bit first from `spi_sdi[0]` sampled at rising edges, and `spi_sdo` holds the current bit while `spi_sck` is high.
- R11: After reset all chip selects are high, and `spi_sck`, `done`, `rx_valid` and `tx_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_step | input | 1 | Half-period strobe from the rate block |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_word | input | 32 | Command word |
| tx_valid | input | 1 | Transmit byte available |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte taken when valid |
| rx_valid | output | 1 | Received byte push strobe |
| rx_data | output | 8 | Received byte |
| done | output | 1 | Frame finished pulse |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 4 | Active-low chip selects |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_oe | output | 1 | Output enable for the data-out line |
| spi_sdi | input | 2 | Serial data in; bit 0 in single-line mode |

## Verification
The hardest situation to reach from the ports is a frame that changes phase in the middle of one chip-select assertion. Such a frame has single-line skip bytes that pull from the transmit stream, followed by dual-line read bytes that pull nothing and take half the edges. On top of that come a transmit stream starved at the start of a byte and a second command offered while the frame runs. The stimulus reaches these by giving each command its own skip, dual and transmit-only settings and by varying the step strobe rate. It holds `tx_valid` low for a set number of cycles and injects a competing command a few cycles into a frame. Every cycle is compared against a behavioural model, and per-frame edge, push and pull counts are compared against values worked out from the command fields.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int CMD_W      = 32;
  localparam int SEL_W      = 2;
  localparam int SEL_LSB    = 30;
  localparam int DUAL_BIT   = 28;
  localparam int TXONLY_BIT = 27;
  localparam int SKIP_W     = 8;
  localparam int SKIP_LSB   = 16;
  localparam int LEN_W      = 16;
  localparam int LEN_LSB    = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              dual;
    logic              tx_only;
    logic [SKIP_W-1:0] skip;
    logic [LEN_W-1:0]  last;
  } cmd_t;
endpackage

// File: rtl/spi_seq_cmd.sv
module spi_seq_cmd
  import spi_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CMD_W-1:0] word,
  output cmd_t             cmd_q
);
  cmd_t cmd_new;
  cmd_t cmd_d;
  logic unused_rsvd;

  // fields that the sequencer uses; the rest of the word is reserved
  assign cmd_new.sel     = word[SEL_LSB +: SEL_W];
  assign cmd_new.dual    = word[DUAL_BIT];
  assign cmd_new.tx_only = word[TXONLY_BIT];
  assign cmd_new.skip    = word[SKIP_LSB +: SKIP_W];
  assign cmd_new.last    = word[LEN_LSB +: LEN_W];
  assign unused_rsvd     = ^{word[29], word[26:24]};

  always_comb begin
    cmd_d = cmd_q;
    if (load) cmd_d = cmd_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end
endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_zero,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  input  logic              sample,
  input  logic              dual,
  input  logic [1:0]        sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)       tx_d = load_zero ? '0 : load_val;
    else if (shift) tx_d = dual ? {tx_q[DATA_W-3:0], 2'b00} : {tx_q[DATA_W-2:0], 1'b0};
    rx_d = rx_q;
    if (sample)     rx_d = dual ? {rx_q[DATA_W-3:0], sdi} : {rx_q[DATA_W-2:0], sdi[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign sdo     = tx_q[DATA_W-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_step,
  input  logic cmd_valid,
  input  cmd_t cmd,
  input  logic tx_valid,
  output logic load_cmd,
  output logic tx_ready,
  output logic sh_load,
  output logic sh_zero,
  output logic sh_shift,
  output logic sh_sample,
  output logic dual_byte,
  output logic sck,
  output logic busy,
  output logic done,
  output logic rx_push,
  output logic sd_oe
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_SINGLE = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] LAST_DUAL   = BIT_W'(DATA_W / 2 - 1);

  seq_state_e       state_q, state_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             sck_q, sck_d;
  logic             done_q, done_d;
  logic             push_q, push_d;

  logic in_skip, read_ph, need_tx, capture, last_byte, last_bit;

  // byte classification for the current byte index
  assign in_skip   = idx_q < LEN_W'(cmd.skip);
  assign read_ph   = (cmd.skip != '0) && !in_skip;
  assign need_tx   = !read_ph;
  assign capture   = !cmd.tx_only && !in_skip;
  assign dual_byte = read_ph && cmd.dual;
  assign last_byte = (idx_q == cmd.last);
  assign last_bit  = (bit_q == (dual_byte ? LAST_DUAL : LAST_SINGLE));

  assign load_cmd  = (state_q == ST_IDLE) && cmd_valid;
  assign tx_ready  = (state_q == ST_FETCH) && need_tx;
  assign busy      = (state_q != ST_IDLE);
  assign sh_zero   = !need_tx;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    bit_d     = bit_q;
    sck_d     = sck_q;
    done_d    = 1'b0;
    push_d    = 1'b0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    sh_sample = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          state_d = ST_FETCH;
          idx_d   = '0;
        end
      end
      ST_FETCH: begin
        if (!need_tx || tx_valid) begin
          sh_load = 1'b1;
          bit_d   = '0;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (sck_step) begin
          if (!sck_q) begin
            sck_d     = 1'b1;
            sh_sample = 1'b1;
          end else begin
            sck_d = 1'b0;
            if (last_bit) begin
              push_d = capture;
              if (last_byte) begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
              end else begin
                state_d = ST_FETCH;
                idx_d   = idx_q + 1'b1;
              end
            end else begin
              sh_shift = 1'b1;
              bit_d    = bit_q + 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      bit_q   <= '0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
      push_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      bit_q   <= bit_d;
      sck_q   <= sck_d;
      done_q  <= done_d;
      push_q  <= push_d;
    end
  end

  assign sck     = sck_q;
  assign done    = done_q;
  assign rx_push = push_q;
  assign sd_oe   = busy && !dual_byte;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_step,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic              spi_sck,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  input  logic [1:0]        spi_sdi
);
  cmd_t cmd_q;
  logic load_cmd, sh_load, sh_zero, sh_shift, sh_sample, dual_byte, busy;

  spi_seq_cmd u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_cmd),
    .word  (cmd_word),
    .cmd_q (cmd_q)
  );

  spi_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_step  (sck_step),
    .cmd_valid (cmd_valid),
    .cmd       (cmd_q),
    .tx_valid  (tx_valid),
    .load_cmd  (load_cmd),
    .tx_ready  (tx_ready),
    .sh_load   (sh_load),
    .sh_zero   (sh_zero),
    .sh_shift  (sh_shift),
    .sh_sample (sh_sample),
    .dual_byte (dual_byte),
    .sck       (spi_sck),
    .busy      (busy),
    .done      (done),
    .rx_push   (rx_valid),
    .sd_oe     (spi_sdo_oe)
  );

  spi_seq_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sh_load),
    .load_zero (sh_zero),
    .load_val  (tx_data),
    .shift     (sh_shift),
    .sample    (sh_sample),
    .dual      (dual_byte),
    .sdi       (spi_sdi),
    .sdo       (spi_sdo),
    .rx_word   (rx_data)
  );

  // one select line per encoding of the select field
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign spi_cs_n[g] = !(busy && (cmd_q.sel == SEL_W'(g)));
  end
endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sck_step,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              done,
  input logic              spi_sck,
  input logic              spi_sdo_oe,
  input logic [NUM_CS-1:0] spi_cs_n
);
  localparam logic [NUM_CS-1:0] ALL_HIGH = '1;

  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1);

  p_cs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n != ALL_HIGH) |=> (spi_cs_n == $past(spi_cs_n)) || (spi_cs_n == ALL_HIGH));

  p_idle_sck_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n == ALL_HIGH) |-> !spi_sck);

  p_step_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_step |=> $stable(spi_sck));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> $stable(spi_sck) && (spi_cs_n != ALL_HIGH));

  p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n == ALL_HIGH) && ($past(spi_cs_n) != ALL_HIGH));

  p_dual_no_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_sdo_oe && (spi_cs_n != ALL_HIGH)) |-> !tx_ready);
endmodule

bind spi_cmd_seq spi_cmd_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck_step   (sck_step),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .done       (done),
  .spi_sck    (spi_sck),
  .spi_sdo_oe (spi_sdo_oe),
  .spi_cs_n   (spi_cs_n)
);

// File: tb/spi_cmd_seq_bench.sv
module spi_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        sck_step;
  logic        cmd_valid;
  logic [31:0] cmd_word;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        done;
  logic        spi_sck;
  logic [3:0]  spi_cs_n;
  logic        spi_sdo;
  logic        spi_sdo_oe;
  logic [1:0]  spi_sdi;

  spi_cmd_seq u_spi_cmd_seq (
    .clk(clk), .rst_n(rst_n), .sck_step(sck_step), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .done(done),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_sdo(spi_sdo),
    .spi_sdo_oe(spi_sdo_oe), .spi_sdi(spi_sdi)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // stimulus state
  logic [7:0] tx_mem [1024];
  int   tx_wr = 0;
  int   tx_en = 1;
  int   step_div = 1;
  int   div_cnt = 0;
  logic [7:0] lfsr = 8'h5A;
  int   mon_on = 0;

  // behavioural reference model state
  int         m_ph;
  int         m_sel, m_len, m_skip, m_idx, m_bits, m_txp;
  bit         m_dual, m_txo, m_sck, m_done, m_rxv;
  logic [7:0] m_sh, m_rx, m_rxd;

  // per-frame counters
  int rises = 0, pushes = 0, pops = 0, dones = 0;
  logic prev_sck = 1'b0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input int sel, input int dual, input int txo,
                                         input int skip, input int len);
    logic [31:0] w;
    w = '0;
    w[31:30] = 2'(sel);
    w[28]    = 1'(dual);
    w[27]    = 1'(txo);
    w[23:16] = 8'(skip);
    w[15:0]  = 16'(len - 1);
    return w;
  endfunction

  function automatic bit m_read_ph();
    return (m_skip != 0) && (m_idx >= m_skip);
  endfunction

  // reference model: advances with the same inputs the design sees
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_sck = 0; m_done = 0; m_rxv = 0; m_txp = 0;
      m_sel = 0; m_len = 1; m_skip = 0; m_idx = 0; m_bits = 0;
      m_dual = 0; m_txo = 0; m_sh = '0; m_rx = '0; m_rxd = '0;
    end else begin
      m_done = 0;
      m_rxv  = 0;
      if (m_ph == 0) begin
        if (cmd_valid) begin
          m_sel  = int'(cmd_word[31:30]);
          m_dual = cmd_word[28];
          m_txo  = cmd_word[27];
          m_skip = int'(cmd_word[23:16]);
          m_len  = int'(cmd_word[15:0]) + 1;
          m_idx  = 0;
          m_ph   = 1;
        end
      end else if (m_ph == 1) begin
        if (m_read_ph()) begin
          m_sh = '0; m_bits = 0; m_ph = 2;
        end else if (tx_valid) begin
          m_sh = tx_data; m_txp++; m_bits = 0; m_ph = 2;
        end
      end else if (sck_step) begin
        if (!m_sck) begin
          m_sck = 1;
          if (m_read_ph() && m_dual) m_rx = {m_rx[5:0], spi_sdi};
          else                       m_rx = {m_rx[6:0], spi_sdi[0]};
        end else begin
          m_sck = 0;
          m_bits++;
          if (m_bits == ((m_read_ph() && m_dual) ? 4 : 8)) begin
            if (!m_txo && !(m_idx < m_skip)) begin
              m_rxv = 1; m_rxd = m_rx;
            end
            if (m_idx == m_len - 1) begin
              m_ph = 0; m_done = 1;
            end else begin
              m_idx++; m_ph = 1;
            end
          end else begin
            m_sh = (m_read_ph() && m_dual) ? {m_sh[5:0], 2'b00} : {m_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  // input drivers, away from the active edge
  always @(negedge clk) begin
    tx_valid = (tx_en != 0) && (m_txp < tx_wr);
    tx_data  = tx_mem[m_txp % 1024];
    spi_sdi  = lfsr[1:0];
    lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (step_div <= 1) sck_step = 1'b1;
    else begin
      sck_step = (div_cnt == 0);
      div_cnt  = (div_cnt + 1) % step_div;
    end
  end

  always @(posedge clk) if (tx_ready && tx_valid) pops++;

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && mon_on != 0) begin
      logic [3:0] e_cs;
      bit e_txr, e_oe;
      e_cs  = (m_ph != 0) ? ~(4'b0001 << m_sel) : 4'hF;
      e_txr = (m_ph == 1) && !m_read_ph();
      e_oe  = (m_ph != 0) && !(m_read_ph() && m_dual);
      chk(spi_cs_n === e_cs, "R1 chip select", int'(spi_cs_n), int'(e_cs));
      chk(spi_sck === m_sck, "R10 serial clock", int'(spi_sck), int'(m_sck));
      chk(tx_ready === e_txr, "R8 tx_ready", int'(tx_ready), int'(e_txr));
      chk(done === m_done, "R7 done pulse", int'(done), int'(m_done));
      chk(rx_valid === m_rxv, "R3 rx push", int'(rx_valid), int'(m_rxv));
      if (m_rxv) chk(rx_data === m_rxd, "R4 rx byte", int'(rx_data), int'(m_rxd));
      chk(spi_sdo_oe === e_oe, "R6 data-out enable", int'(spi_sdo_oe), int'(e_oe));
      if (m_sck && m_ph == 2) chk(spi_sdo === m_sh[7], "R10 data out bit", int'(spi_sdo), int'(m_sh[7]));
      if (spi_sck && !prev_sck) rises++;
      if (rx_valid) pushes++;
      if (done) dones++;
      prev_sck = spi_sck;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input int sel, input int dual, input int txo, input int skip,
                     input int len, input int div, input int stall, input int intrude);
    int r, e_rises, e_push, e_pop, t;
    r       = (skip > 0 && skip < len) ? len - skip : 0;
    e_pop   = (skip > 0) ? len - r : len;
    e_rises = (len - r) * 8 + r * ((dual != 0 && skip > 0) ? 4 : 8);
    e_push  = (txo != 0) ? 0 : ((skip > 0) ? r : len);
    for (int i = 0; i < e_pop; i++) begin
      tx_mem[tx_wr % 1024] = 8'((i * 37 + len * 11 + sel) & 8'hFF);
      tx_wr++;
    end
    @(negedge clk);
    step_div = div; div_cnt = 0;
    rises = 0; pushes = 0; pops = 0; dones = 0;
    tx_en = (stall == 0) ? 1 : 0;
    cmd_valid = 1'b1;
    cmd_word  = mk_cmd(sel, dual, txo, skip, len);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      chk(spi_cs_n === ~(4'b0001 << sel), "R8 select held while starved", int'(spi_cs_n), int'(~(4'b0001 << sel)));
      chk(spi_sck === 1'b0, "R8 clock held while starved", int'(spi_sck), 0);
      chk(tx_ready === 1'b1, "R8 ready while starved", int'(tx_ready), 1);
      tx_en = 1;
    end
    if (intrude > 0) begin
      repeat (intrude) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_word  = mk_cmd(sel ^ 1, 0, 0, 0, 2);
      @(negedge clk);
      cmd_valid = 1'b0;
      @(negedge clk);
      chk(spi_cs_n === ~(4'b0001 << sel), "R9 command while busy ignored", int'(spi_cs_n), int'(~(4'b0001 << sel)));
    end
    t = 0;
    while (dones == 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(rises == e_rises, "R2/R6 rising edges per frame", rises, e_rises);
    chk(pushes == e_push, "R3/R4/R5 bytes pushed", pushes, e_push);
    chk(pops == e_pop, "R4 bytes pulled", pops, e_pop);
    chk(dones == 1, "R7 done count", dones, 1);
    chk(spi_cs_n === 4'hF, "R1 idle selects", int'(spi_cs_n), 15);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0;
    sck_step = 1'b0; tx_valid = 1'b0; tx_data = '0; spi_sdi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(spi_cs_n === 4'hF, "R11 selects after reset", int'(spi_cs_n), 15);
    chk(spi_sck === 1'b0, "R11 clock after reset", int'(spi_sck), 0);
    chk(done === 1'b0, "R11 done after reset", int'(done), 0);
    chk(rx_valid === 1'b0, "R11 rx_valid after reset", int'(rx_valid), 0);
    chk(tx_ready === 1'b0, "R11 tx_ready after reset", int'(tx_ready), 0);
    mon_on = 1;
    run(0, 0, 0, 0, 1, 1, 0, 0);   // R2 single byte frame
    run(1, 0, 0, 0, 4, 3, 0, 0);   // R4 full duplex, slow step
    run(2, 0, 0, 2, 6, 1, 0, 0);   // R3 R4 skip then single read
    run(3, 1, 0, 3, 7, 2, 0, 0);   // R6 dual read after skip
    run(1, 1, 0, 0, 5, 1, 0, 0);   // R6 dual flag ignored without skip
    run(0, 0, 1, 0, 4, 2, 0, 0);   // R5 transmit-only
    run(2, 1, 1, 2, 5, 1, 0, 0);   // R5 transmit-only with dual read phase
    run(3, 0, 0, 3, 3, 1, 0, 0);   // R3 skip covers the whole frame
    run(1, 0, 0, 0, 3, 2, 20, 0);  // R8 starved transmit stream
    run(0, 0, 0, 0, 6, 1, 0, 4);   // R9 command while busy
    run(2, 1, 0, 4, 40, 1, 0, 0);  // R2 R6 longer frame
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule